// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block sits between a simple single-word request port and an asynchronous DRAM whose address pins are shared between the row and column halves of the address. Each request carries a full 16-bit address. The controller first places the upper byte on the 8 address pins and drops the active-low row strobe. It then places the lower byte on the same pins and drops the active-low column strobe. For a write, it sets the active-low write strobe and drives the data bus before the column strobe falls. For a read, it samples the data bus a programmable number of cycles after the column strobe falls.

Dynamic cells lose their charge, so the controller also runs its own refresh timer. The timer divides the retention period into 256 equal slots, one per row. When a slot expires, a refresh is marked pending. The next arbitration point serves it as a row-strobe-only cycle: the row counter is placed on the pins, the row strobe is pulsed low, and the column strobe stays high. A pending refresh wins over a waiting request, but it never cuts into an access that has already begun. The row strobe is always held high for a minimum precharge time between two low periods.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, `dq_oe_o` is 0 and `ack_o` is 0.
- R2: On an access, `dram_addr_o` carries `addr_i[15:8]` when `ras_n_o` falls and `addr_i[7:0]` when `cas_n_o` later falls; `cas_n_o` is 0 only while `ras_n_o` is 0.
- R3: The column address, `we_n_o` (0 for a write, 1 for a read), and for a write `dq_oe_o`=1 with `dq_o` equal to the write data, are all set at least one clock before `cas_n_o` falls and are unchanged at that fall.
- R4: A read captures `dram_dq_i` at the clock edge `T_CAS` cycles after the edge at which `cas_n_o` fell, and returns it on `rdata_o` while `ack_o` is 1.
- R5: A write stores `wdata_i` at `addr_i`, so a later read of that address returns it.
- R6: A refresh is a cycle in which `ras_n_o` goes low with `cas_n_o` and `we_n_o` kept at 1. `dram_addr_o` carries the refresh row, and the refresh row goes 0, 1, 2, … and wraps after 255.
- R7: A refresh becomes due every REF_INT = (RET_MS*CLK_KHZ − 64)/256 clock cycles, counted from reset. Every row sees a `ras_n_o` fall within RET_MS*CLK_KHZ cycles of the previous fall on that row, or of reset.
- R8: A due refresh starts before any waiting access and no later than T_RCD+T_CAS+T_RP+8 cycles after it became due. It never starts while an access holds `ras_n_o` low.
- R9: Between two low periods, `ras_n_o` stays high for at least `T_RP` cycles.
- R10: `ack_o` is a one-cycle pulse at the end of each access. `req_i`, `we_i`, `addr_i` and `wdata_i` must be held until `ack_o` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (16) | Word address |
| wdata_i | input | DW (16) | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW (16) | Read data, valid with ack |
| dram_addr_o | output | AW/2 (8) | Multiplexed row/column address pins |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| dq_o | output | DW (16) | Data toward DRAM |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dram_dq_i | input | DW (16) | Data from DRAM |

## Verification
The assertions assume a well-behaved request port. Once `req_i` rises, it and the address, direction and write data stay unchanged until `ack_o`. After `ack_o`, `req_i` drops before the controller could take a new request. The bench drives its inputs on falling clock edges and holds them across the whole access. It releases them only on the falling edge where it sees `ack_o`. The DRAM model in the bench returns a deliberately wrong value until `T_CAS` edges after the column strobe falls. It decides what counts as an access or a refresh only from the strobes it sees on the pins.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RSET, ST_RAS, ST_CSET, ST_CAS
  } seq_st_e;

  typedef enum logic [1:0] {
    SEL_ROW, SEL_COL, SEL_REF
  } asel_e;

  localparam int unsigned REF_GUARD = 64;
endpackage

// File: rtl/dram_refresh_tmr.sv
module dram_refresh_tmr #(
  parameter int unsigned REF_INT = 31,
  parameter int unsigned ROW_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned TW = (REF_INT > 1) ? $clog2(REF_INT) : 1;

  logic [TW-1:0] tick_q;
  logic          expire;

  assign expire = (tick_q == TW'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      tick_q <= expire ? '0 : tick_q + 1'b1;
      pend_o <= expire | (pend_o & ~take_i);
      if (take_i) row_o <= row_o + 1'b1;
    end
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  asel_e             sel_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [AW/2-1:0]   ref_row_i,
  output logic [AW/2-1:0]   pin_o
);
  localparam int unsigned HW = AW / 2;

  always_comb begin
    unique case (sel_i)
      SEL_COL: pin_o = acc_addr_i[HW-1:0];
      SEL_REF: pin_o = ref_row_i;
      default: pin_o = acc_addr_i[AW-1:HW];
    endcase
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RFW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  input  logic            ref_pend_i,
  output logic            ref_take_o,
  output logic            acc_start_o,
  output logic            ref_act_o,
  output asel_e           sel_o,
  output logic [AW-1:0]   acc_addr_o,
  input  logic [AW/2-1:0] mux_i,
  output logic [AW/2-1:0] dram_addr_o,
  output logic            ras_n_o,
  output logic            cas_n_o,
  output logic            we_n_o,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe_o,
  input  logic [DW-1:0]   dram_dq_i
);
  localparam int unsigned TMAX = (T_RCD > T_CAS) ? ((T_RCD > T_RFW) ? T_RCD : T_RFW)
                                                 : ((T_CAS > T_RFW) ? T_CAS : T_RFW);
  localparam int unsigned CW = $clog2(TMAX + 1);
  localparam int unsigned PW = $clog2(T_RP + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pre_q;
  logic          is_ref_q, is_we_q;
  logic [AW-1:0] addr_q;
  logic          pre_ok;

  assign pre_ok      = (pre_q >= PW'(T_RP));
  assign ref_take_o  = (st_q == ST_IDLE) && pre_ok && ref_pend_i;
  assign acc_start_o = (st_q == ST_IDLE) && pre_ok && !ref_pend_i && req_i;
  assign ref_act_o   = is_ref_q && (st_q != ST_IDLE);
  assign acc_addr_o  = (st_q == ST_IDLE) ? addr_i : addr_q;

  always_comb begin
    sel_o = SEL_ROW;
    if (st_q == ST_IDLE && ref_pend_i) sel_o = SEL_REF;
    else if (st_q == ST_RAS)           sel_o = SEL_COL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      pre_q       <= PW'(T_RP);
      is_ref_q    <= 1'b0;
      is_we_q     <= 1'b0;
      addr_q      <= '0;
      dq_o        <= '0;
      dram_addr_o <= '0;
      ras_n_o     <= 1'b1;
      cas_n_o     <= 1'b1;
      we_n_o      <= 1'b1;
      dq_oe_o     <= 1'b0;
      ack_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      ack_o <= 1'b0;
      if (ras_n_o && !pre_ok) pre_q <= pre_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (ref_take_o || acc_start_o) begin
            st_q        <= ST_RSET;
            dram_addr_o <= mux_i;
            is_ref_q    <= ref_take_o;
            is_we_q     <= we_i;
            addr_q      <= addr_i;
            dq_o        <= wdata_i;
          end
        end
        ST_RSET: begin
          ras_n_o <= 1'b0;
          cnt_q   <= is_ref_q ? CW'(T_RFW - 1) : CW'(T_RCD - 1);
          st_q    <= ST_RAS;
        end
        ST_RAS: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (is_ref_q) begin
            ras_n_o <= 1'b1;
            pre_q   <= '0;
            st_q    <= ST_IDLE;
          end else begin
            dram_addr_o <= mux_i;
            we_n_o      <= ~is_we_q;
            dq_oe_o     <= is_we_q;
            st_q        <= ST_CSET;
          end
        end
        ST_CSET: begin
          cas_n_o <= 1'b0;
          cnt_q   <= CW'(T_CAS - 1);
          st_q    <= ST_CAS;
        end
        ST_CAS: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            if (!is_we_q) rdata_o <= dram_dq_i;
            ras_n_o <= 1'b1;
            cas_n_o <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
            pre_q   <= '0;
            ack_o   <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned RET_MS  = 4,
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_CAS   = 2,
  parameter int unsigned T_RFW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic [AW/2-1:0] dram_addr_o,
  output logic            ras_n_o,
  output logic            cas_n_o,
  output logic            we_n_o,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe_o,
  input  logic [DW-1:0]   dram_dq_i
);
  localparam int unsigned ROW_W   = AW / 2;
  localparam int unsigned ROWS    = 1 << ROW_W;
  localparam int unsigned RET_CYC = RET_MS * CLK_KHZ;
  localparam int unsigned REF_INT = (RET_CYC - REF_GUARD) / ROWS;

  logic             ref_pend, ref_take, acc_start, ref_act;
  logic [ROW_W-1:0] ref_row, mux_pin;
  logic [AW-1:0]    acc_addr;
  asel_e            sel;

  dram_refresh_tmr #(.REF_INT(REF_INT), .ROW_W(ROW_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(ref_take),
    .pend_o(ref_pend), .row_o(ref_row)
  );

  dram_addr_mux #(.AW(AW)) u_mux (
    .sel_i(sel), .acc_addr_i(acc_addr), .ref_row_i(ref_row), .pin_o(mux_pin)
  );

  dram_seq #(
    .AW(AW), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RFW(T_RFW)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ack_o(ack_o), .rdata_o(rdata_o),
    .ref_pend_i(ref_pend), .ref_take_o(ref_take),
    .acc_start_o(acc_start), .ref_act_o(ref_act),
    .sel_o(sel), .acc_addr_o(acc_addr), .mux_i(mux_pin),
    .dram_addr_o(dram_addr_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dram_dq_i(dram_dq_i)
  );
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned T_RP = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_o,
  input logic [AW/2-1:0] dram_addr_o,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          we_n_o,
  input logic          dq_oe_o,
  input logic          ref_pend,
  input logic          ref_take,
  input logic          acc_start,
  input logic          ref_act
);
  localparam int unsigned HW = $clog2(T_RP + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hi_cnt <= HW'(T_RP);
    else if (!ras_n_o)              hi_cnt <= '0;
    else if (hi_cnt < HW'(T_RP))    hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o); // R2
  AST_COL_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> ($stable(dram_addr_o) && $stable(we_n_o) && $stable(dq_oe_o))); // R3
  AST_ACK_AFTER_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(!cas_n_o) && cas_n_o)); // R4
  AST_REF_RAS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_act |-> (cas_n_o && we_n_o)); // R6
  AST_REF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_start |-> !ref_pend); // R8
  AST_REF_NO_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_take |-> (ras_n_o && cas_n_o)); // R8
  AST_RAS_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= HW'(T_RP))); // R9
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R10
endmodule

bind dram_ctrl dram_ctrl_chk #(.AW(AW), .T_RP(T_RP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .dram_addr_o(dram_addr_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .dq_oe_o(dq_oe_o),
  .ref_pend(ref_pend), .ref_take(ref_take), .acc_start(acc_start), .ref_act(ref_act)
);

// File: tb/sim_dram_ctrl.sv
module sim_dram_ctrl;
  localparam int AW = 16, DW = 16, RET_MS = 4, CLK_KHZ = 2000;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, T_RFW = 3;
  localparam int ROWS = 256;
  localparam int RET_CYC = RET_MS * CLK_KHZ;
  localparam int REF_INT = (RET_CYC - 64) / ROWS;
  localparam int LAT = T_RCD + T_CAS + T_RP + 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, dq_in = '0;
  logic ack, ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_out;
  logic [AW/2-1:0] pins;

  always #10 clk = ~clk;

  dram_ctrl #(.AW(AW), .DW(DW), .RET_MS(RET_MS), .CLK_KHZ(CLK_KHZ),
              .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RFW(T_RFW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .dram_addr_o(pins),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .dq_o(dq_out),
    .dq_oe_o(dq_oe), .dram_dq_i(dq_in)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req_tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
    return a ^ 16'h5A5A;
  endfunction

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  // cell array model, observing pins on falling clock edges
  logic [DW-1:0] cells [int];
  logic [DW-1:0] exp_mem [int];
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_data = '0;
  bit op_we = 0;
  bit ras_d = 1, cas_d = 1, we_d = 1, oe_d = 0, cas_seen = 0;
  logic [7:0] row_cap = '0, pins_d = '0;
  int cas_cnt = 0, hi_cnt = T_RP, fall_cyc = 0, ref_seen = 0;
  int last_ref [ROWS];

  initial for (int i = 0; i < ROWS; i++) last_ref[i] = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!ras_n && ras_d) begin
        chk(hi_cnt >= T_RP, "R9", "ras high cycles", hi_cnt, T_RP);
        row_cap = pins; fall_cyc = cyc; cas_seen = 0;
        last_ref[pins] = cyc;
      end
      if (ras_n && !ras_d && !cas_seen) begin
        chk(row_cap == 8'(ref_seen % ROWS), "R6", "refresh row", row_cap, ref_seen % ROWS);
        chk(fall_cyc >= (ref_seen + 1) * REF_INT && fall_cyc <= (ref_seen + 1) * REF_INT + LAT,
            "R8", "refresh start cycle", fall_cyc, (ref_seen + 1) * REF_INT);
        ref_seen++;
      end
      if (!cas_n && cas_d) begin
        cas_seen = 1;
        chk(!ras_n, "R2", "cas fell with ras high", ras_n, 0);
        chk({row_cap, pins} == op_addr, "R2", "row/col captured", {row_cap, pins}, op_addr);
        chk(we_n == !op_we, "R3", "we_n at cas fall", we_n, !op_we);
        chk(pins == pins_d && we_n == we_d && dq_oe == oe_d, "R3", "setup before cas",
            {pins_d, we_d, oe_d}, {pins, we_n, dq_oe});
        if (!we_n) begin
          chk(dq_oe && dq_out == op_data, "R3", "write data on bus", dq_out, op_data);
          cells[{row_cap, pins}] = dq_out;
        end
        cas_cnt = 1;
      end else if (!cas_n) cas_cnt++;
      if (!cas_n && !ras_n && cas_cnt >= T_CAS)
        dq_in = cells.exists({row_cap, pins}) ? cells[{row_cap, pins}] : init_val({row_cap, pins});
      else
        dq_in = 16'hDEAD;
      hi_cnt = ras_n ? hi_cnt + 1 : 0;
      begin
        bit ret_ok = 1;
        int worst = 0;
        for (int r = 0; r < ROWS; r++)
          if (cyc - last_ref[r] > RET_CYC) begin ret_ok = 0; worst = r; end
        chk(ret_ok, "R7", "row retention exceeded for row", worst, RET_CYC);
      end
    end
    ras_d = ras_n; cas_d = cas_n; we_d = we_n; oe_d = dq_oe; pins_d = pins;
  end

  task automatic do_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    op_addr = a; op_we = w; op_data = d;
    do @(negedge clk); while (!ack && !finished);
    if (w) exp_mem[a] = d;
    else chk(rdata == (exp_mem.exists(a) ? exp_mem[a] : init_val(a)), w ? "R5" : "R4",
             "read data", rdata, exp_mem.exists(a) ? exp_mem[a] : init_val(a));
    req = 0;
    @(negedge clk);
    chk(!ack, "R10", "ack single pulse", ack, 0);
  endtask

  initial begin
    int unsigned seed = 32'h1234_5678;
    logic [AW-1:0] pool [8];
    pool = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'h1234, 16'h8001, 16'h7F80, 16'hA55A};
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && !dq_oe && !ack, "R1", "strobes in reset",
        {ras_n, cas_n, we_n, dq_oe, ack}, 5'b11100);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(ras_n && cas_n && we_n && !dq_oe && !ack, "R1", "strobes after reset",
        {ras_n, cas_n, we_n, dq_oe, ack}, 5'b11100);
    // R4: unwritten corners read their initial contents
    for (int i = 0; i < 8; i++) do_op(0, pool[i], '0);
    // R5: write each corner then read back
    for (int i = 0; i < 8; i++) do_op(1, pool[i], 16'hC000 | 16'(i * 37));
    for (int i = 0; i < 8; i++) do_op(0, pool[i], '0);
    // mixed traffic with random gaps
    for (int n = 0; n < 500 && !finished; n++) begin
      logic [AW-1:0] a;
      seed = seed * 1103515245 + 12345;
      a = seed[20] ? pool[seed[18:16]] : {seed[27:24], 4'h0, seed[11:8], seed[3:0]};
      do_op(seed[30], a, seed[15:0] ^ 16'h3C3C);
      repeat (seed[23:21]) @(negedge clk);
    end
    while (cyc < 3 * RET_CYC && !finished) @(negedge clk);
    chk(ref_seen >= (3 * RET_CYC) / REF_INT - 2, "R7", "refresh count", ref_seen,
        (3 * RET_CYC) / REF_INT);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 3 * RET_CYC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule